// File: doc/BRIEF.md
# Drive Status and Command Decoder

This block is the drive-side decoder for a floppy mechanism controller. The host drives four function-select lines and a command strobe. The block assembles the select lines into a 4-bit function code. While the strobe is idle, the code picks one of sixteen drive conditions, and the block presents that condition on a single sense output. A rising strobe instead executes a control action chosen by the same code, such as setting the step direction, stepping the head, switching the spindle motor or ejecting the disk.

The block holds the drive's mechanical state: step direction, current track, motor, selected head and the disk-switched flag. It times head steps and disk ejection with down-counters, so the host sees realistic busy windows. Most sense values are active-low. Two of the codes also act when they are only selected: they pick which head the data path uses. All inputs pass through a synchronizer, and the sense output is registered.

Top module: `drive_cmd_status`

## Requirements
- R1: The function code is formed as bit0 = `phase2`, bit1 = `side_sel`, bit2 = `phase0`, bit3 = `phase1`.
- R2: With the drive enabled, the sense output reports the condition named by the code:
  - 0x0: step direction (1 = outward).
  - 0x2: 0 when a disk is inserted.
  - 0x6: 0 when the disk is write protected.
  - 0x8: 0 when the motor runs.
  - 0x9: 1, meaning a double-sided drive.
  - 0xE: follows `tach_in`.
  - 0xF: 0, meaning a drive is connected.
  - Every unlisted code reads 1.
- R3: Selecting code 0x1 while enabled sets `head_upper` to 0. Selecting code 0x3 while enabled sets it to 1.
- R4: On a rising strobe, the block executes the command named by the code:
  - 0x0 sets the direction inward (status 0x0 reads 0).
  - 0x1 sets the direction outward.
  - 0x8 turns the motor on.
  - 0x9 turns the motor off.
- R5: Command 0x4 moves the track one position: up when the direction is inward, down when it is outward. The track saturates at 0 and at MAX_TRACK.
- R6: A step keeps status 0x4 at 0 for STEP_CYCLES cycles, and a step command during that window is ignored. Status 0xA reads 0 only at track 0 with no step in progress.
- R7: Command 0xD raises `eject_run` for EJECT_CYCLES cycles and stops the motor. Commands arriving during that window are ignored.
- R8: A falling edge on `disk_in` makes status 0xC read 0. Command 0x3 returns it to 1.
- R9: While `drv_en` is low, the sense output reads 1, and strobes and head selection have no effect.
- R10: Status 0xB reads 0 only when the motor runs, no step is in progress and a disk is inserted.
- R11: After reset, the state is: direction inward, track 0, motor off, head lower, no eject, disk-switched flag reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase0 | input | 1 | Function select, code bit 2 |
| phase1 | input | 1 | Function select, code bit 3 |
| phase2 | input | 1 | Function select, code bit 0 (on/off value for commands) |
| side_sel | input | 1 | Function select, code bit 1 |
| cmd_strobe | input | 1 | A rising edge executes a command |
| drv_en | input | 1 | Drive enable |
| disk_in | input | 1 | 1 when a disk is inserted |
| wr_protect | input | 1 | 1 when the disk is write protected |
| tach_in | input | 1 | Tachometer pulse source |
| sense | output | 1 | Selected status bit (registered) |
| head_upper | output | 1 | 1 when the upper head is selected |
| motor_run | output | 1 | Spindle motor request |
| eject_run | output | 1 | High while an eject is in progress |
| track_pos | output | $clog2(MAX_TRACK+1) | Current track |

## Verification
Assertions check the following on every cycle:
- The track never exceeds MAX_TRACK and moves at most one position per cycle.
- Direction and track stay frozen and the motor stays off during an eject.
- The step counter only counts down.
- The sense output is 1 one cycle after the enable drops.
- The head select changes only when code 0x1 or 0x3 is selected.
- The ready status reads 1 whenever the motor is off.

The bench's directed and random scenarios cover the rest, which properties cannot capture:
- the bit order of the code;
- the polarity of each status code;
- the timed busy windows of steps and ejects;
- saturation at both ends of the track range;
- the disk-switched flag's set and clear sequence.

// File: rtl/drv_pkg.sv
package drv_pkg;
  typedef logic [3:0] fcode_t;

  // status selections
  localparam fcode_t FC_DIR       = 4'h0;
  localparam fcode_t FC_LOWER     = 4'h1;
  localparam fcode_t FC_PRESENT   = 4'h2;
  localparam fcode_t FC_UPPER     = 4'h3;
  localparam fcode_t FC_STEPPING  = 4'h4;
  localparam fcode_t FC_WPROT     = 4'h6;
  localparam fcode_t FC_MOTOR     = 4'h8;
  localparam fcode_t FC_SIDES     = 4'h9;
  localparam fcode_t FC_TRK0      = 4'hA;
  localparam fcode_t FC_READY     = 4'hB;
  localparam fcode_t FC_SWITCHED  = 4'hC;
  localparam fcode_t FC_TACH      = 4'hE;
  localparam fcode_t FC_INSTALLED = 4'hF;

  // strobed commands
  localparam fcode_t CM_DIR_IN    = 4'h0;
  localparam fcode_t CM_DIR_OUT   = 4'h1;
  localparam fcode_t CM_CLR_SW    = 4'h3;
  localparam fcode_t CM_STEP      = 4'h4;
  localparam fcode_t CM_MOTOR_ON  = 4'h8;
  localparam fcode_t CM_MOTOR_OFF = 4'h9;
  localparam fcode_t CM_EJECT     = 4'hD;

  // code bit order: {p1, p0, side, p2}
  function automatic fcode_t pack_code(input logic p0, input logic p1,
                                       input logic p2, input logic side);
    return {p1, p0, side, p2};
  endfunction
endpackage

// File: rtl/drv_in_stage.sv
module drv_in_stage #(
  parameter int STAGES = 2,
  parameter int W      = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/drv_mech.sv
module drv_mech
  import drv_pkg::*;
#(
  parameter int MAX_TRACK    = 79,
  parameter int STEP_CYCLES  = 1200000,
  parameter int EJECT_CYCLES = 50000000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  fcode_t                       code,
  input  logic                         en,
  input  logic                         strobe,
  input  logic                         disk,
  output logic                         dir_out,
  output logic [$clog2(MAX_TRACK+1)-1:0] track,
  output logic                         motor,
  output logic                         sw_n,
  output logic                         step_busy,
  output logic                         ej_busy
);
  localparam int TW  = $clog2(MAX_TRACK + 1);
  localparam int SCW = $clog2(STEP_CYCLES + 1);
  localparam int ECW = $clog2(EJECT_CYCLES + 1);
  localparam logic [TW-1:0]  TMAX    = TW'(MAX_TRACK);
  localparam logic [SCW-1:0] STEP_LD = SCW'(STEP_CYCLES);
  localparam logic [ECW-1:0] EJ_LD   = ECW'(EJECT_CYCLES);

  logic           strb_prev, disk_prev;
  logic [SCW-1:0] step_cnt;
  logic [ECW-1:0] ej_cnt;
  logic           fire, accept;

  assign fire      = en & strobe & ~strb_prev;
  assign step_busy = (step_cnt != '0);
  assign ej_busy   = (ej_cnt != '0);
  assign accept    = fire & ~ej_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev <= 1'b0;
      disk_prev <= 1'b0;
      dir_out   <= 1'b0;
      track     <= '0;
      motor     <= 1'b0;
      sw_n      <= 1'b1;
      step_cnt  <= '0;
      ej_cnt    <= '0;
    end else begin
      strb_prev <= strobe;
      disk_prev <= disk;
      if (step_busy) step_cnt <= step_cnt - SCW'(1);
      if (ej_busy)   ej_cnt   <= ej_cnt - ECW'(1);
      if (accept) begin
        case (code)
          CM_DIR_IN:    dir_out <= 1'b0;
          CM_DIR_OUT:   dir_out <= 1'b1;
          CM_CLR_SW:    sw_n    <= 1'b1;
          CM_MOTOR_ON:  motor   <= 1'b1;
          CM_MOTOR_OFF: motor   <= 1'b0;
          CM_STEP: begin
            if (!step_busy) begin
              step_cnt <= STEP_LD;
              if (dir_out) begin
                if (track != '0) track <= track - TW'(1);
              end else begin
                if (track != TMAX) track <= track + TW'(1);
              end
            end
          end
          CM_EJECT: begin
            ej_cnt <= EJ_LD;
            motor  <= 1'b0;
          end
          default: ;
        endcase
      end
      // removal wins over a clear in the same cycle
      if (disk_prev & ~disk) sw_n <= 1'b0;
    end
  end

  // R5: track stays within its range
  a_r5_track_in_range: assert property (@(posedge clk) disable iff (rst)
    track <= TMAX);

  // R5: track moves at most one position per cycle
  a_r5_single_move: assert property (@(posedge clk) disable iff (rst)
    (track != $past(track)) |->
      (track == $past(track) + TW'(1)) || (track + TW'(1) == $past(track)));

  // R7: nothing is changed while an eject runs
  a_r7_frozen_in_eject: assert property (@(posedge clk) disable iff (rst)
    ej_busy |=> $stable(dir_out) && $stable(track));

  // R7: motor stays off during an eject
  a_r7_motor_off_in_eject: assert property (@(posedge clk) disable iff (rst)
    ej_busy |-> !motor);

  // R6: a running step only counts down, never retriggers
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    step_busy |=> step_cnt == $past(step_cnt) - SCW'(1));
endmodule

// File: rtl/drv_status.sv
module drv_status
  import drv_pkg::*;
#(
  parameter bit DOUBLE_SIDED = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  fcode_t code,
  input  logic   en,
  input  logic   dir_out,
  input  logic   disk,
  input  logic   wprot,
  input  logic   step_busy,
  input  logic   motor,
  input  logic   at_zero,
  input  logic   sw_n,
  input  logic   tach,
  output logic   sense,
  output logic   head_upper
);
  logic bit_val;

  always_comb begin
    case (code)
      FC_DIR:       bit_val = dir_out;
      FC_PRESENT:   bit_val = ~disk;
      FC_STEPPING:  bit_val = ~step_busy;
      FC_WPROT:     bit_val = ~wprot;
      FC_MOTOR:     bit_val = ~motor;
      FC_SIDES:     bit_val = DOUBLE_SIDED;
      FC_TRK0:      bit_val = ~(at_zero & ~step_busy);
      FC_READY:     bit_val = ~(motor & ~step_busy & disk);
      FC_SWITCHED:  bit_val = sw_n;
      FC_TACH:      bit_val = tach;
      FC_INSTALLED: bit_val = 1'b0;
      default:      bit_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense      <= 1'b1;
      head_upper <= 1'b0;
    end else begin
      sense <= en ? bit_val : 1'b1;
      if (en && code == FC_LOWER) head_upper <= 1'b0;
      if (en && code == FC_UPPER) head_upper <= 1'b1;
    end
  end

  // R9: disabled drive reports 1
  a_r9_idle_sense_high: assert property (@(posedge clk) disable iff (rst)
    !en |=> sense);

  // R3: head changes only on an enabled head selection
  a_r3_head_on_select: assert property (@(posedge clk) disable iff (rst)
    (head_upper != $past(head_upper)) |->
      $past(en) && ($past(code) == FC_LOWER || $past(code) == FC_UPPER));

  // R10: never ready with the motor off
  a_r10_not_ready_motor_off: assert property (@(posedge clk) disable iff (rst)
    (en && code == FC_READY && !motor) |=> sense);
endmodule

// File: rtl/drive_cmd_status.sv
module drive_cmd_status
  import drv_pkg::*;
#(
  parameter int MAX_TRACK    = 79,
  parameter int STEP_CYCLES  = 1200000,
  parameter int EJECT_CYCLES = 50000000,
  parameter int SYNC_STAGES  = 2,
  parameter bit DOUBLE_SIDED = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           phase0,
  input  logic                           phase1,
  input  logic                           phase2,
  input  logic                           side_sel,
  input  logic                           cmd_strobe,
  input  logic                           drv_en,
  input  logic                           disk_in,
  input  logic                           wr_protect,
  input  logic                           tach_in,
  output logic                           sense,
  output logic                           head_upper,
  output logic                           motor_run,
  output logic                           eject_run,
  output logic [$clog2(MAX_TRACK+1)-1:0] track_pos
);
  localparam int NW = 9;

  logic [NW-1:0] raw_v, syn_v;
  fcode_t        code_s;
  logic          dir_out, sw_n, step_busy;

  // R1: code bits assembled from the select lines
  assign raw_v = {tach_in, wr_protect, disk_in, drv_en, cmd_strobe,
                  pack_code(phase0, phase1, phase2, side_sel)};
  assign code_s = syn_v[3:0];

  drv_in_stage #(.STAGES(SYNC_STAGES), .W(NW)) u_sync (
    .clk(clk), .rst(rst), .raw(raw_v), .synced(syn_v)
  );

  drv_mech #(
    .MAX_TRACK(MAX_TRACK), .STEP_CYCLES(STEP_CYCLES), .EJECT_CYCLES(EJECT_CYCLES)
  ) u_mech (
    .clk(clk), .rst(rst), .code(code_s), .en(syn_v[5]), .strobe(syn_v[4]),
    .disk(syn_v[6]), .dir_out(dir_out), .track(track_pos), .motor(motor_run),
    .sw_n(sw_n), .step_busy(step_busy), .ej_busy(eject_run)
  );

  drv_status #(.DOUBLE_SIDED(DOUBLE_SIDED)) u_stat (
    .clk(clk), .rst(rst), .code(code_s), .en(syn_v[5]), .dir_out(dir_out),
    .disk(syn_v[6]), .wprot(syn_v[7]), .step_busy(step_busy), .motor(motor_run),
    .at_zero(track_pos == '0), .sw_n(sw_n), .tach(syn_v[8]),
    .sense(sense), .head_upper(head_upper)
  );
endmodule

// File: tb/drive_cmd_status_bench.sv
module drive_cmd_status_bench;
  localparam int MAXT = 5;
  localparam int STEPC = 40;
  localparam int EJC = 60;

  logic clk = 0, rst = 1;
  logic phase0 = 0, phase1 = 0, phase2 = 0, side_sel = 0, cmd_strobe = 0;
  logic drv_en = 1, disk_in = 0, wr_protect = 0, tach_in = 0;
  logic sense, head_upper, motor_run, eject_run;
  logic [2:0] track_pos;

  int errors = 0, checks = 0;
  // model state
  bit m_dir = 0, m_motor = 0, m_sw = 1, m_head = 0;
  int m_track = 0;

  always #5 clk = ~clk;

  drive_cmd_status #(.MAX_TRACK(MAXT), .STEP_CYCLES(STEPC), .EJECT_CYCLES(EJC))
    u_drive_cmd_status (
    .clk(clk), .rst(rst), .phase0(phase0), .phase1(phase1), .phase2(phase2),
    .side_sel(side_sel), .cmd_strobe(cmd_strobe), .drv_en(drv_en),
    .disk_in(disk_in), .wr_protect(wr_protect), .tach_in(tach_in),
    .sense(sense), .head_upper(head_upper), .motor_run(motor_run),
    .eject_run(eject_run), .track_pos(track_pos));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // R1: bit0=phase2, bit1=side_sel, bit2=phase0, bit3=phase1
  task automatic set_code(input logic [3:0] c);
    phase2 = c[0]; side_sel = c[1]; phase0 = c[2]; phase1 = c[3];
    if (drv_en && c == 4'h1) m_head = 0;
    if (drv_en && c == 4'h3) m_head = 1;
  endtask

  function automatic bit exp_status(input logic [3:0] c);
    case (c)
      4'h0: return m_dir;
      4'h2: return !disk_in;
      4'h4: return 1'b1;
      4'h6: return !wr_protect;
      4'h8: return !m_motor;
      4'h9: return 1'b1;
      4'hA: return !(m_track == 0);
      4'hB: return !(m_motor && disk_in);
      4'hC: return m_sw;
      4'hE: return tach_in;
      4'hF: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic void apply_cmd(input logic [3:0] c);
    case (c)
      4'h0: m_dir = 0;
      4'h1: m_dir = 1;
      4'h3: m_sw = 1;
      4'h4: m_track = m_dir ? ((m_track > 0) ? m_track - 1 : 0)
                            : ((m_track < MAXT) ? m_track + 1 : MAXT);
      4'h8: m_motor = 1;
      4'h9: m_motor = 0;
      4'hD: m_motor = 0;
      default: ;
    endcase
  endfunction

  task automatic issue(input logic [3:0] c);
    @(negedge clk); set_code(c);
    repeat (3) @(negedge clk);
    cmd_strobe = 1;
    repeat (4) @(negedge clk);
    cmd_strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read(input logic [3:0] c, output bit s);
    @(negedge clk); set_code(c);
    repeat (6) @(negedge clk);
    s = sense;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit s;
    logic [3:0] cmds [7] = '{4'h0, 4'h1, 4'h3, 4'h4, 4'h8, 4'h9, 4'hD};
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 0;
    wait_cyc(6);
    // R11 reset state
    check("R11 sense dir", sense, 0);
    check("R11 motor", motor_run, 0);
    check("R11 track", track_pos, 0);
    check("R11 head", head_upper, 0);
    check("R11 eject", eject_run, 0);
    read(4'hC, s); check("R11 switched flag", s, 1);
    // R2 fixed codes
    read(4'hF, s); check("R2 installed", s, 0);
    read(4'h9, s); check("R2 sides", s, 1);
    read(4'h5, s); check("R2 unlisted code", s, 1);
    disk_in = 1; wr_protect = 1;
    read(4'h2, s); check("R1 R2 disk present", s, 0);
    read(4'h6, s); check("R1 R2 protected", s, 0);
    wr_protect = 0;
    read(4'h6, s); check("R2 writable", s, 1);
    tach_in = 1; read(4'hE, s); check("R2 tach high", s, 1);
    tach_in = 0; read(4'hE, s); check("R2 tach low", s, 0);
    // R3 head select
    read(4'h3, s); check("R3 upper head", head_upper, 1);
    read(4'h1, s); check("R3 lower head", head_upper, 0);
    // R4 motor, R10 ready
    read(4'hB, s); check("R10 not ready motor off", s, 1);
    issue(4'h8); apply_cmd(4'h8);
    check("R4 motor on", motor_run, 1);
    read(4'h8, s); check("R4 motor status", s, 0);
    read(4'hB, s); check("R10 ready", s, 0);
    // R6 stepping
    issue(4'h0); apply_cmd(4'h0);
    issue(4'h4); apply_cmd(4'h4);
    read(4'h4, s); check("R6 stepping", s, 0);
    read(4'hB, s); check("R10 not ready while stepping", s, 1);
    issue(4'h4);                 // ignored: step in progress
    wait_cyc(50);
    check("R6 retrigger ignored", track_pos, 1);
    read(4'h4, s); check("R6 step done", s, 1);
    read(4'hA, s); check("R6 not track zero", s, 1);
    // R5 outward and saturation at zero
    issue(4'h1); apply_cmd(4'h1);
    read(4'h0, s); check("R4 direction outward", s, 1);
    issue(4'h4); apply_cmd(4'h4);
    read(4'hA, s); check("R6 track zero hidden while stepping", s, 1);
    wait_cyc(50);
    read(4'hA, s); check("R6 track zero", s, 0);
    issue(4'h4); apply_cmd(4'h4); wait_cyc(50);
    check("R5 saturate at zero", track_pos, 0);
    issue(4'h0); apply_cmd(4'h0);
    read(4'h0, s); check("R4 direction inward", s, 0);
    for (int i = 0; i < MAXT + 2; i++) begin
      issue(4'h4); apply_cmd(4'h4); wait_cyc(45);
    end
    check("R5 saturate at max", track_pos, MAXT);
    // R8 disk switched
    disk_in = 0; wait_cyc(4);
    read(4'hC, s); check("R8 switched set", s, 0);
    read(4'h2, s); check("R2 disk absent", s, 1);
    disk_in = 1;
    issue(4'h3); apply_cmd(4'h3);
    read(4'hC, s); check("R8 switched cleared", s, 1);
    // R7 eject
    issue(4'h8); apply_cmd(4'h8);
    issue(4'hD); apply_cmd(4'hD);
    check("R7 eject active", eject_run, 1);
    check("R7 motor stopped", motor_run, 0);
    issue(4'h8);                 // ignored during eject
    check("R7 command ignored", motor_run, 0);
    wait_cyc(70);
    check("R7 eject done", eject_run, 0);
    check("R7 motor still off", motor_run, 0);
    // R9 disabled drive
    read(4'h1, s);
    drv_en = 0; wait_cyc(4);
    read(4'h0, s); check("R9 sense high when disabled", s, 1);
    issue(4'h8); check("R9 strobe ignored", motor_run, 0);
    read(4'h3, s); check("R9 head select ignored", head_upper, 0);
    drv_en = 1; wait_cyc(4);
    // random mix, R2 R4 R5 R3 R8
    for (int n = 0; n < 40; n++) begin
      logic [3:0] c, q;
      if ($urandom % 5 == 0) begin
        if (disk_in) m_sw = 0;
        disk_in = ~disk_in;
        wait_cyc(4);
      end
      wr_protect = $urandom % 2;
      tach_in = $urandom % 2;
      c = cmds[$urandom % 7];
      issue(c); apply_cmd(c);
      wait_cyc(70);
      check("R5 random track", track_pos, m_track);
      check("R4 random motor", motor_run, m_motor);
      q = 4'($urandom % 16);
      read(q, s);
      check($sformatf("R2 random status %0h", q), s, exp_status(q));
      check("R3 random head", head_upper, m_head);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule